// File: doc/BRIEF.md
# Partition Element Router with Neighbour Ring

This block is one node of a ring that spreads a single logical hash table across several memory partitions. Prefetched index elements from this partition enter on a stream input. A hash of each element gives its global set number, and the upper bits of that set number name the partition that owns it. Elements owned locally wait in a local queue for the hash insert port. All others wait in a forward queue and then leave on a one-way ring towards the neighbour partition.

Traffic arriving from the other neighbour is either taken off the ring, when it is addressed to this partition, or passed on unchanged one cycle later. Elements taken off the ring are buffered in an eject queue. The eject queue is served before the local queue at the insert port. Backpressure on the insert port never stops the ring. When the eject queue is full, an element addressed to this node is sent once more around the ring instead of being dropped.

Top module: `ringpart_node`

## Requirements
- R1: While reset is held and immediately after it, `rout_valid` and `ins_valid` are 0 and `pf_ready` is 1.
- R2: The set number of an element is bits [14:5] of the 24-bit element (element divided by 32, modulo 1024). The owning partition is bits [9:8] of the set number. `ins_set` carries the set number of `ins_data`, and its owner field always equals the node's own partition number.
- R3: An accepted element owned by this partition is offered on the insert port in the cycle after acceptance. Local elements are delivered in arrival order.
- R4: An accepted element owned by another partition leaves on the ring output two cycles after acceptance when the ring is idle. Its destination field equals its owner, and forwarded elements keep their arrival order.
- R5: A valid ring flit whose destination differs from this partition appears on the ring output in the next cycle with the same destination and data.
- R6: Pass-through ring traffic takes priority over injection from the forward queue. A waiting forward element is sent only in a cycle with no pass-through flit.
- R7: A ring flit addressed to this partition is taken off the ring and offered on the insert port. When both the eject queue and the local queue hold elements, the eject queue is served first, unless a local element is already being offered under stall.
- R8: While `ins_valid` is 1 and `ins_ready` is 0, the insert port holds the same element. Pass-through ring traffic continues during the stall.
- R9: A ring flit addressed to this partition that arrives while the eject queue is full is sent out on the ring output in the next cycle, unchanged.
- R10: `pf_ready` is 0 exactly when the queue that the presented element maps to (local or forward) is full. An element presented while `pf_ready` is 0 is not taken and never appears at any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pf_valid | input | 1 | Prefetched element present |
| pf_data | input | 24 | Prefetched element (index) |
| pf_ready | output | 1 | Element accepted this cycle when valid |
| rin_valid | input | 1 | Flit arriving from the upstream neighbour |
| rin_dst | input | 2 | Destination partition of the arriving flit |
| rin_data | input | 24 | Element carried by the arriving flit |
| rout_valid | output | 1 | Flit sent to the downstream neighbour |
| rout_dst | output | 2 | Destination partition of the outgoing flit |
| rout_data | output | 24 | Element carried by the outgoing flit |
| ins_valid | output | 1 | Element offered to the local hash table |
| ins_data | output | 24 | Element to insert |
| ins_set | output | 10 | Global set number of the offered element |
| ins_ready | input | 1 | Hash table takes the offered element |

## Verification
The routing function is tried with a stream of locally owned elements, a stream of remote elements spread over all three other owners, and ring flits both addressed here and passing through. Together these separate the classifier decision from the ring decision. A collision pattern presents a new forward element and two back-to-back pass-through flits at once, so the output order shows whether pass-through wins. A second collision pattern lands a local element and an ejected ring element in the same cycle under a stalled insert port, so the delivery order shows which queue is served first. Holding the insert port stalled while the eject queue fills, and then while the local queue fills, exposes recirculation on the ring and refusal at the prefetch input.

// File: rtl/ringpart_pkg.sv
`timescale 1ns/1ps
package ringpart_pkg;
  localparam int ELEM_W = 24;
  localparam int SET_W  = 10;
  localparam int LINE_B = 5;
  localparam int NPART  = 4;
  localparam int PID_W  = $clog2(NPART);

  typedef logic [ELEM_W-1:0] elem_t;
  typedef logic [SET_W-1:0]  set_t;
  typedef logic [PID_W-1:0]  pid_t;

  typedef struct packed {
    logic  vld;
    pid_t  dst;
    elem_t data;
  } flit_t;

  // global set: cache-line number folded into the set range
  function automatic set_t set_of(elem_t e);
    return e[LINE_B +: SET_W];
  endfunction

  // partition owning an element: top bits of its set
  function automatic pid_t owner_of(elem_t e);
    set_t s;
    s = set_of(e);
    return s[SET_W-1 -: PID_W];
  endfunction
endpackage

// File: rtl/rp_fifo.sv
`timescale 1ns/1ps
module rp_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end
endmodule

// File: rtl/rp_ring_stage.sv
`timescale 1ns/1ps
module rp_ring_stage
  import ringpart_pkg::*;
#(
  parameter int PART_ID = 0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rin_valid,
  input  pid_t  rin_dst,
  input  elem_t rin_data,
  input  logic  ej_full,
  input  logic  fwd_empty,
  input  elem_t fwd_head,
  output logic  rout_valid,
  output pid_t  rout_dst,
  output elem_t rout_data,
  output logic  ej_push,
  output logic  fwd_pop
);
  localparam pid_t MY_ID = pid_t'(PART_ID);

  logic  for_me;
  logic  pass_evt;
  flit_t nxt_flit, out_q;

  assign for_me   = rin_valid && (rin_dst == MY_ID);
  assign ej_push  = for_me && !ej_full;
  // foreign flits and own flits that cannot be ejected keep circulating
  assign pass_evt = rin_valid && !ej_push;
  assign fwd_pop  = !pass_evt && !fwd_empty;

  always_comb begin
    nxt_flit = '0;
    if (pass_evt) begin
      nxt_flit.vld  = 1'b1;
      nxt_flit.dst  = rin_dst;
      nxt_flit.data = rin_data;
    end else if (fwd_pop) begin
      nxt_flit.vld  = 1'b1;
      nxt_flit.dst  = owner_of(fwd_head);
      nxt_flit.data = fwd_head;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= nxt_flit;
  end

  assign rout_valid = out_q.vld;
  assign rout_dst   = out_q.dst;
  assign rout_data  = out_q.data;
endmodule

// File: rtl/rp_ins_arb.sv
`timescale 1ns/1ps
module rp_ins_arb
  import ringpart_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ej_empty,
  input  elem_t ej_head,
  input  logic  loc_empty,
  input  elem_t loc_head,
  input  logic  ins_ready,
  output logic  ins_valid,
  output elem_t ins_data,
  output logic  ej_pop,
  output logic  loc_pop
);
  logic hold_loc;
  logic grant_loc, grant_ej;

  // ring-delivered elements first, but never swap an element under stall
  assign grant_loc = !loc_empty && (hold_loc || ej_empty);
  assign grant_ej  = !ej_empty && !grant_loc;
  assign ins_valid = grant_loc || grant_ej;
  assign ins_data  = grant_loc ? loc_head : ej_head;
  assign ej_pop    = grant_ej && ins_ready;
  assign loc_pop   = grant_loc && ins_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) hold_loc <= 1'b0;
    else        hold_loc <= grant_loc && !ins_ready;
  end
endmodule

// File: rtl/ringpart_node.sv
`timescale 1ns/1ps
module ringpart_node #(
  parameter int PART_ID    = 0,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             pf_valid,
  input  logic [ringpart_pkg::ELEM_W-1:0]  pf_data,
  output logic                             pf_ready,
  input  logic                             rin_valid,
  input  logic [ringpart_pkg::PID_W-1:0]   rin_dst,
  input  logic [ringpart_pkg::ELEM_W-1:0]  rin_data,
  output logic                             rout_valid,
  output logic [ringpart_pkg::PID_W-1:0]   rout_dst,
  output logic [ringpart_pkg::ELEM_W-1:0]  rout_data,
  output logic                             ins_valid,
  output logic [ringpart_pkg::ELEM_W-1:0]  ins_data,
  output logic [ringpart_pkg::SET_W-1:0]   ins_set,
  input  logic                             ins_ready
);
  import ringpart_pkg::*;

  localparam pid_t MY_ID = pid_t'(PART_ID);

  // named internal events (also observed by the checker)
  logic  pf_local;
  logic  loc_push, fwd_push, ej_push;
  logic  loc_pop, fwd_pop, ej_pop;
  logic  loc_empty, fwd_empty, ej_empty;
  logic  loc_full, fwd_full, ej_full;
  elem_t loc_head, fwd_head, ej_head;

  // classifier
  assign pf_local = (owner_of(pf_data) == MY_ID);
  assign pf_ready = pf_local ? !loc_full : !fwd_full;
  assign loc_push = pf_valid && pf_ready && pf_local;
  assign fwd_push = pf_valid && pf_ready && !pf_local;

  rp_fifo #(.W(ELEM_W), .DEPTH(FIFO_DEPTH)) u_loc (
    .clk(clk), .rst_n(rst_n), .push(loc_push), .din(pf_data),
    .pop(loc_pop), .dout(loc_head), .empty(loc_empty), .full(loc_full)
  );

  rp_fifo #(.W(ELEM_W), .DEPTH(FIFO_DEPTH)) u_fwd (
    .clk(clk), .rst_n(rst_n), .push(fwd_push), .din(pf_data),
    .pop(fwd_pop), .dout(fwd_head), .empty(fwd_empty), .full(fwd_full)
  );

  rp_fifo #(.W(ELEM_W), .DEPTH(FIFO_DEPTH)) u_ej (
    .clk(clk), .rst_n(rst_n), .push(ej_push), .din(rin_data),
    .pop(ej_pop), .dout(ej_head), .empty(ej_empty), .full(ej_full)
  );

  rp_ring_stage #(.PART_ID(PART_ID)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .rin_valid(rin_valid), .rin_dst(rin_dst), .rin_data(rin_data),
    .ej_full(ej_full), .fwd_empty(fwd_empty), .fwd_head(fwd_head),
    .rout_valid(rout_valid), .rout_dst(rout_dst), .rout_data(rout_data),
    .ej_push(ej_push), .fwd_pop(fwd_pop)
  );

  rp_ins_arb u_arb (
    .clk(clk), .rst_n(rst_n),
    .ej_empty(ej_empty), .ej_head(ej_head),
    .loc_empty(loc_empty), .loc_head(loc_head),
    .ins_ready(ins_ready), .ins_valid(ins_valid), .ins_data(ins_data),
    .ej_pop(ej_pop), .loc_pop(loc_pop)
  );

  assign ins_set = set_of(ins_data);
endmodule

// File: rtl/ringpart_chk.sv
`timescale 1ns/1ps
module ringpart_chk
  import ringpart_pkg::*;
#(
  parameter int PART_ID = 0
) (
  input logic  clk,
  input logic  rst_n,
  input logic  pf_valid,
  input logic  pf_ready,
  input logic  rin_valid,
  input pid_t  rin_dst,
  input elem_t rin_data,
  input logic  rout_valid,
  input pid_t  rout_dst,
  input elem_t rout_data,
  input logic  ins_valid,
  input elem_t ins_data,
  input set_t  ins_set,
  input logic  ins_ready,
  input logic  ej_full,
  input logic  ej_empty,
  input logic  ej_pop,
  input logic  loc_full,
  input logic  fwd_full
);
  localparam pid_t MY_ID = pid_t'(PART_ID);

  // R5
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rin_valid && rin_dst != MY_ID |=>
      rout_valid && rout_dst == $past(rin_dst) && rout_data == $past(rin_data));

  // R9
  recirculate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rin_valid && rin_dst == MY_ID && ej_full |=>
      rout_valid && rout_dst == MY_ID && rout_data == $past(rin_data));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && !ins_ready |=> ins_valid && $stable(ins_data));

  // R7
  ring_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && ins_ready && !ej_empty && !$past(ins_valid && !ins_ready) |-> ej_pop);

  // R10
  refuse_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_ready |-> loc_full || fwd_full);

  // R2
  own_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |-> ins_set[SET_W-1 -: PID_W] == MY_ID);
endmodule

bind ringpart_node ringpart_chk #(.PART_ID(PART_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .pf_valid(pf_valid), .pf_ready(pf_ready),
  .rin_valid(rin_valid), .rin_dst(rin_dst), .rin_data(rin_data),
  .rout_valid(rout_valid), .rout_dst(rout_dst), .rout_data(rout_data),
  .ins_valid(ins_valid), .ins_data(ins_data), .ins_set(ins_set),
  .ins_ready(ins_ready), .ej_full(ej_full), .ej_empty(ej_empty),
  .ej_pop(ej_pop), .loc_full(loc_full), .fwd_full(fwd_full)
);

// File: tb/sim_ringpart_node.sv
`timescale 1ns/1ps
module sim_ringpart_node;
  import ringpart_pkg::*;

  localparam int PID   = 1;
  localparam int DEP   = 4;
  localparam int LOW_W = LINE_B + SET_W - PID_W;

  logic  clk = 1'b0;
  always #2 clk = ~clk;

  logic  rst_n, pf_valid, pf_ready, rin_valid, rout_valid, ins_valid, ins_ready;
  elem_t pf_data, rin_data, rout_data, ins_data;
  pid_t  rin_dst, rout_dst;
  set_t  ins_set;

  ringpart_node #(.PART_ID(PID), .FIFO_DEPTH(DEP)) u0 (
    .clk(clk), .rst_n(rst_n), .pf_valid(pf_valid), .pf_data(pf_data),
    .pf_ready(pf_ready), .rin_valid(rin_valid), .rin_dst(rin_dst),
    .rin_data(rin_data), .rout_valid(rout_valid), .rout_dst(rout_dst),
    .rout_data(rout_data), .ins_valid(ins_valid), .ins_data(ins_data),
    .ins_set(ins_set), .ins_ready(ins_ready)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  elem_t                  qi_d[$];
  string                  qi_r[$];
  logic [PID_W+ELEM_W-1:0] qr_d[$];
  string                  qr_r[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // element with a chosen owner partition and low bits
  function automatic elem_t mk(input int o, input int lo);
    elem_t e;
    e = '0;
    e[LINE_B+SET_W-1 -: PID_W] = PID_W'(o);
    e[LOW_W-1:0] = LOW_W'(lo);
    return e;
  endfunction

  function automatic set_t exp_set(input elem_t e);
    return set_t'((int'(e) / (1 << LINE_B)) % (1 << SET_W));
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic exp_ins(input elem_t e, input string r);
    qi_d.push_back(e); qi_r.push_back(r);
  endtask

  task automatic exp_ring(input int o, input elem_t e, input string r);
    qr_d.push_back({PID_W'(o), e}); qr_r.push_back(r);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1.5;
      if (rst_n && !done) begin
        if (ins_valid && ins_ready) begin
          if (qi_d.size() == 0) chk(1'b0, "R3 unexpected insert", 32'(ins_data), 32'hx);
          else begin
            elem_t e; string r;
            e = qi_d.pop_front(); r = qi_r.pop_front();
            chk(ins_data == e, r, 32'(ins_data), 32'(e));
            // R2 set number of the delivered element
            chk(ins_set == exp_set(e), "R2 ins_set", 32'(ins_set), 32'(exp_set(e)));
          end
        end
        if (rout_valid) begin
          if (qr_d.size() == 0) chk(1'b0, "R4 unexpected ring flit", 32'({rout_dst, rout_data}), 32'hx);
          else begin
            logic [PID_W+ELEM_W-1:0] f; string r;
            f = qr_d.pop_front(); r = qr_r.pop_front();
            chk({rout_dst, rout_data} == f, r, 32'({rout_dst, rout_data}), 32'(f));
          end
        end
      end
    end
  end

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pf_valid = 1'b0; pf_data = '0; rin_valid = 1'b0;
    rin_dst = '0; rin_data = '0; ins_ready = 1'b1;
    repeat (3) tick();
    #1;
    // R1 reset state
    chk(rout_valid == 1'b0, "R1 rout_valid in reset", 32'(rout_valid), 0);
    chk(ins_valid == 1'b0, "R1 ins_valid in reset", 32'(ins_valid), 0);
    chk(pf_ready == 1'b1, "R1 pf_ready in reset", 32'(pf_ready), 1);
    tick(); rst_n = 1'b1;
    #1;
    chk(rout_valid == 1'b0 && ins_valid == 1'b0, "R1 outputs after reset", 32'({rout_valid, ins_valid}), 0);

    // R3 local stream
    for (int i = 0; i < 3; i++) begin
      tick(); pf_valid = 1'b1; pf_data = mk(PID, i + 1); exp_ins(pf_data, "R3 local order");
    end
    tick(); pf_valid = 1'b0;
    repeat (5) tick();

    // R4 remote stream over all other owners
    for (int i = 0; i < 3; i++) begin
      tick(); pf_valid = 1'b1; pf_data = mk((PID + 1 + i) % NPART, 40 + i);
      exp_ring((PID + 1 + i) % NPART, pf_data, "R4 forward dst/data");
    end
    tick(); pf_valid = 1'b0;
    repeat (5) tick();

    // R5 pass-through
    for (int i = 0; i < 3; i++) begin
      tick(); rin_valid = 1'b1; rin_dst = pid_t'((PID + 1 + i) % NPART);
      rin_data = mk((PID + 1 + i) % NPART, 100 + i);
      exp_ring((PID + 1 + i) % NPART, rin_data, "R5 pass-through");
    end
    tick(); rin_valid = 1'b0;
    repeat (4) tick();

    // R6 pass-through beats injection
    tick(); pf_valid = 1'b1; pf_data = mk(2, 150);
    rin_valid = 1'b1; rin_dst = 2'd3; rin_data = mk(3, 151);
    exp_ring(3, mk(3, 151), "R6 first pass flit");
    exp_ring(0, mk(0, 152), "R6 second pass flit");
    exp_ring(2, mk(2, 150), "R6 injected after pass");
    tick(); pf_valid = 1'b0; rin_dst = 2'd0; rin_data = mk(0, 152);
    tick(); rin_valid = 1'b0;
    repeat (5) tick();

    // R7 eject served before local, R8 hold under stall
    ins_ready = 1'b0;
    tick(); pf_valid = 1'b1; pf_data = mk(PID, 160);
    rin_valid = 1'b1; rin_dst = pid_t'(PID); rin_data = mk(PID, 161);
    exp_ins(mk(PID, 161), "R7 ring element first");
    exp_ins(mk(PID, 160), "R7 local element second");
    tick(); pf_valid = 1'b0; rin_dst = 2'd2; rin_data = mk(2, 162);
    exp_ring(2, mk(2, 162), "R8 ring moves during stall");
    tick(); rin_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(ins_valid == 1'b1 && ins_data == mk(PID, 161), "R8 held under stall",
          32'(ins_data), 32'(mk(PID, 161)));
      tick();
    end
    ins_ready = 1'b1;
    repeat (5) tick();

    // R9 recirculation when eject queue is full
    ins_ready = 1'b0;
    for (int i = 0; i < DEP + 1; i++) begin
      tick(); rin_valid = 1'b1; rin_dst = pid_t'(PID); rin_data = mk(PID, 200 + i);
      if (i < DEP) exp_ins(rin_data, "R9 ejected element");
      else         exp_ring(PID, rin_data, "R9 recirculated own flit");
    end
    tick(); rin_valid = 1'b0;
    tick(); ins_ready = 1'b1;
    repeat (8) tick();

    // R10 refusal when target queue full
    ins_ready = 1'b0;
    for (int i = 0; i < DEP; i++) begin
      tick(); pf_valid = 1'b1; pf_data = mk(PID, 300 + i); exp_ins(pf_data, "R10 local before full");
    end
    tick(); pf_data = mk(2, 390);
    #1;
    chk(pf_ready == 1'b1, "R10 ready for other queue", 32'(pf_ready), 1);
    pf_data = mk(PID, 399);
    #1;
    chk(pf_ready == 1'b0, "R10 refused when local full", 32'(pf_ready), 0);
    tick(); #1;
    chk(pf_ready == 1'b0, "R10 still refused", 32'(pf_ready), 0);
    tick(); pf_valid = 1'b0; ins_ready = 1'b1;
    repeat (8) tick();
    #1;
    chk(ins_valid == 1'b0, "R10 refused element not delivered", 32'(ins_valid), 0);
    chk(rout_valid == 1'b0, "R10 nothing on ring", 32'(rout_valid), 0);
    chk(qi_d.size() == 0, "R3 all inserts seen", qi_d.size(), 0);
    chk(qr_d.size() == 0, "R4 all ring flits seen", qr_d.size(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule